// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Controller

This block is the digital control section of a 32-tap digitally adjusted resistor. A host moves the wiper with three lines: an active-low select, a direction level and a step strobe. Each falling edge of the strobe moves the wiper by one position while the block is selected. The position is held in a saturating counter and decoded to a one-hot tap-select vector that drives the switch network of the resistor array.

The block also keeps a register that stands in for the nonvolatile cell. The host leaves select in one of two ways. If the strobe is high when select rises, the current position is written to that register and a busy flag marks the store cycle. If the strobe is low, nothing is written. A warm reset models a power cycle: the counter reloads from the stored position. A separate cold reset gives the stored register its factory value. All three inputs pass through two-flop synchronizers, so the block can run on a fast system clock with a slow host.

Top module: `wiper_ctrl`

## Requirements
- R1: `tap_sel` always has exactly one bit set, and that bit is the one whose index equals `pos`.
- R2: While `cs_n` is low and no store is running, a high-to-low transition of `inc` with `up_dn` high raises `pos` by one.
- R3: Under the same conditions, with `up_dn` low, the falling edge lowers `pos` by one.
- R4: The counter does not wrap. A step up at position 31 or a step down at position 0 leaves `pos` unchanged. `pos` never moves by more than one per clock.
- R5: While `cs_n` is high, `inc` edges leave `pos` unchanged. A rising edge of `inc` never moves the wiper.
- R6: A low-to-high transition of `cs_n` while `inc` is high copies `pos` into the stored register. `busy` is then high for exactly STORE_CYC clock cycles.
- R7: A low-to-high transition of `cs_n` while `inc` is low stores nothing and leaves `busy` low. `pos` keeps its value.
- R8: While `busy` is high, falling edges of `inc` leave `pos` unchanged, even with `cs_n` low.
- R9: After a warm reset (`rst_n` low) `pos` equals the last stored position. After a cold reset (`por_n` low) the stored position, and so `pos`, equals INIT_POS (16 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Cold reset, active low, asynchronous assert; also sets the stored position to INIT_POS |
| rst_n | input | 1 | Warm (power-cycle) reset, active low, asynchronous assert; the counter reloads the stored position |
| cs_n | input | 1 | Select, active low; its rising edge ends a session |
| up_dn | input | 1 | Step direction: 1 = up, 0 = down |
| inc | input | 1 | Step strobe; acts on its falling edge |
| pos | output | POS_W (5) | Current wiper position |
| tap_sel | output | 2**POS_W (32) | One-hot tap select |
| busy | output | 1 | High while a store cycle runs |

## Verification
On every cycle the assertions check that the tap vector is one-hot and matches the position. They also check that the position moves by at most one step and never wraps, that it holds still while a store runs, and that a busy period never exceeds the store length. Other behaviour shows only in the bench's scenarios: the direction of each step, saturation reached by sweeps from both ends, and the two ways of leaving the selected state. The stored value itself is visible at the ports only after a warm reset, so the bench observes it there. The bench also shows that pulses on the strobe are ignored while deselected and during a store.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // State of the store sequencer
  typedef enum logic {
    SAVE_IDLE = 1'b0,
    SAVE_BUSY = 1'b1
  } save_state_e;

  // Saturating one-step move of an unsigned position
  function automatic logic [15:0] sat_step(input logic [15:0] cur,
                                           input logic        up,
                                           input logic [15:0] max_val);
    logic [15:0] res;
    if (up) res = (cur == max_val) ? cur : cur + 16'd1;
    else    res = (cur == 16'd0)   ? cur : cur - 16'd1;
    return res;
  endfunction

endpackage

// File: rtl/wiper_rst_sync.sv
module wiper_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/wiper_input_front.sv
module wiper_input_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic srst_n,
  input  logic cs_n,
  input  logic up_dn,
  input  logic inc,
  output logic sel_n_lvl,
  output logic up_lvl,
  output logic inc_lvl,
  output logic inc_fall,
  output logic sel_rise
);
  localparam int NSIG = 3;
  // idle levels: deselected, direction down, strobe high
  localparam logic [NSIG-1:0] IDLE_LVL = 3'b101;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] stage_q [SYNC_STAGES];
  logic [NSIG-1:0] stage_d [SYNC_STAGES];
  logic [NSIG-1:0] synced;
  logic [NSIG-1:0] prev_q;
  logic [NSIG-1:0] prev_d;

  assign raw = {cs_n, up_dn, inc};

  // synchronizer chain, depth set by parameter
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = raw;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) stage_q[s] <= IDLE_LVL;
      else         stage_q[s] <= stage_d[s];
    end
  end

  assign synced = stage_q[SYNC_STAGES-1];
  assign prev_d = synced;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) prev_q <= IDLE_LVL;
    else         prev_q <= prev_d;
  end

  assign sel_n_lvl = synced[2];
  assign up_lvl    = synced[1];
  assign inc_lvl   = synced[0];
  assign inc_fall  = prev_q[0] & ~synced[0];
  assign sel_rise  = ~prev_q[2] & synced[2];
endmodule

// File: rtl/wiper_pos_counter.sv
module wiper_pos_counter
  import wiper_pkg::*;
#(
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             step_req,
  input  logic             step_up,
  input  logic [POS_W-1:0] recall_val,
  output logic [POS_W-1:0] pos
);
  localparam logic [15:0] POS_MAX = 16'((1 << POS_W) - 1);

  logic             recall_q;
  logic             recall_d;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic             pos_en;

  // next-state
  always_comb begin
    recall_d = 1'b0;
    pos_en   = recall_q | step_req;
    pos_d    = pos_q;
    if (recall_q) begin
      pos_d = recall_val;
    end else if (step_req) begin
      pos_d = POS_W'(sat_step(16'(pos_q), step_up, POS_MAX));
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      recall_q <= 1'b1;
      pos_q    <= '0;
    end else begin
      recall_q <= recall_d;
      if (pos_en) pos_q <= pos_d;
    end
  end

  assign pos = pos_q;
endmodule

// File: rtl/wiper_tap_decoder.sv
module wiper_tap_decoder #(
  parameter int POS_W = 5,
  localparam int NTAP = 1 << POS_W
) (
  input  logic [POS_W-1:0] pos,
  output logic [NTAP-1:0]  tap_sel
);
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign tap_sel[t] = (pos == POS_W'(t));
  end
endmodule

// File: rtl/wiper_store_ctrl.sv
module wiper_store_ctrl
  import wiper_pkg::*;
#(
  parameter int POS_W     = 5,
  parameter int STORE_CYC = 500000,
  parameter int INIT_POS  = 16
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             cold_srst_n,
  input  logic             save_req,
  input  logic [POS_W-1:0] pos,
  output logic             busy,
  output logic [POS_W-1:0] nv_pos
);
  localparam int CNT_W = (STORE_CYC > 1) ? $clog2(STORE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STORE_CYC - 1);

  save_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [POS_W-1:0] nv_q, nv_d;
  logic             nv_en;

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    nv_en   = 1'b0;
    nv_d    = pos;
    unique case (state_q)
      SAVE_IDLE: begin
        if (save_req) begin
          state_d = SAVE_BUSY;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          nv_en   = 1'b1;
        end
      end
      SAVE_BUSY: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) begin
          state_d = SAVE_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = SAVE_IDLE;
    endcase
  end

  // sequencer registers (warm domain)
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= SAVE_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // stored position (cold domain only)
  always_ff @(posedge clk or negedge cold_srst_n) begin
    if (!cold_srst_n) nv_q <= POS_W'(INIT_POS);
    else if (nv_en)   nv_q <= nv_d;
  end

  assign busy   = (state_q == SAVE_BUSY);
  assign nv_pos = nv_q;
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int POS_W     = 5,
  parameter int STORE_CYC = 500000,
  parameter int INIT_POS  = 16,
  localparam int NTAP     = 1 << POS_W
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             up_dn,
  input  logic             inc,
  output logic [POS_W-1:0] pos,
  output logic [NTAP-1:0]  tap_sel,
  output logic             busy
);
  logic warm_arst_n;
  logic sys_srst_n;
  logic cold_srst_n;
  logic sel_n_lvl, up_lvl, inc_lvl, inc_fall, sel_rise;
  logic step_req, save_req;
  logic [POS_W-1:0] nv_pos;

  assign warm_arst_n = rst_n & por_n;

  wiper_rst_sync u_rst_warm (.clk(clk), .arst_n(warm_arst_n), .srst_n(sys_srst_n));
  wiper_rst_sync u_rst_cold (.clk(clk), .arst_n(por_n),       .srst_n(cold_srst_n));

  wiper_input_front #(.SYNC_STAGES(2)) u_front (
    .clk(clk), .srst_n(sys_srst_n),
    .cs_n(cs_n), .up_dn(up_dn), .inc(inc),
    .sel_n_lvl(sel_n_lvl), .up_lvl(up_lvl), .inc_lvl(inc_lvl),
    .inc_fall(inc_fall), .sel_rise(sel_rise)
  );

  assign step_req = inc_fall & ~sel_n_lvl & ~busy;
  assign save_req = sel_rise & inc_lvl;

  wiper_pos_counter #(.POS_W(POS_W)) u_cnt (
    .clk(clk), .srst_n(sys_srst_n),
    .step_req(step_req), .step_up(up_lvl),
    .recall_val(nv_pos), .pos(pos)
  );

  wiper_tap_decoder #(.POS_W(POS_W)) u_dec (.pos(pos), .tap_sel(tap_sel));

  wiper_store_ctrl #(.POS_W(POS_W), .STORE_CYC(STORE_CYC), .INIT_POS(INIT_POS)) u_store (
    .clk(clk), .srst_n(sys_srst_n), .cold_srst_n(cold_srst_n),
    .save_req(save_req), .pos(pos), .busy(busy), .nv_pos(nv_pos)
  );
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int POS_W     = 5,
  parameter int STORE_CYC = 500000,
  localparam int NTAP     = 1 << POS_W,
  localparam int PW1      = POS_W + 1,
  localparam int RUN_W    = $clog2(STORE_CYC + 2) + 1
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic [POS_W-1:0] pos,
  input logic [NTAP-1:0]  tap_sel,
  input logic             busy
);
  logic             any_rst_n;
  logic [2:0]       arm_q;
  logic             armed;
  logic [RUN_W-1:0] run_q;

  assign any_rst_n = por_n & rst_n;
  assign armed     = (arm_q == 3'd7);

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) begin
      arm_q <= '0;
      run_q <= '0;
    end else begin
      if (!armed) arm_q <= arm_q + 3'd1;
      run_q <= busy ? run_q + RUN_W'(1) : '0;
    end
  end

  // R1
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
    armed |-> ($onehot0(tap_sel) && tap_sel[pos]));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
    armed |=> ((PW1'(pos) == PW1'($past(pos))) ||
               (PW1'(pos) == PW1'($past(pos)) + PW1'(1)) ||
               (PW1'(pos) + PW1'(1) == PW1'($past(pos)))));

  // R8
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
    (armed && busy) |=> $stable(pos));

  // R6
  busy_length_chk: assert property (@(posedge clk) disable iff (!any_rst_n)
    run_q <= RUN_W'(STORE_CYC));
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.POS_W(POS_W), .STORE_CYC(STORE_CYC)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n),
  .pos(pos), .tap_sel(tap_sel), .busy(busy)
);

// File: tb/tb_wiper_ctrl.sv
module tb_wiper_ctrl;
  localparam int POS_W = 5;
  localparam int NTAP  = 1 << POS_W;
  localparam int SCYC  = 40;
  localparam int INIT  = 16;
  localparam int PMAX  = NTAP - 1;

  logic clk = 1'b0;
  logic por_n, rst_n, cs_n, up_dn, inc;
  logic [POS_W-1:0] pos;
  logic [NTAP-1:0]  tap_sel;
  logic busy;

  int n_chk = 0;
  int n_bad = 0;
  int exp_pos;
  int exp_nv;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wiper_ctrl #(.POS_W(POS_W), .STORE_CYC(SCYC), .INIT_POS(INIT)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs_n(cs_n),
    .up_dn(up_dn), .inc(inc), .pos(pos), .tap_sel(tap_sel), .busy(busy)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pos(input string req);
    logic [NTAP-1:0] exp_tap;
    exp_tap = NTAP'(1) << exp_pos;
    check(int'(pos) == exp_pos, req, int'(pos), exp_pos);
    check(tap_sel == exp_tap, {req, "/R1 tap"}, $clog2(int'(tap_sel) + 1), exp_pos);
  endtask

  // one strobe pulse; model updates only when the block must act
  task automatic step(input logic dir, input bit hold_low, input bit acts);
    up_dn = dir;
    wait_cyc(4);
    inc = 1'b0;
    wait_cyc(6);
    if (!hold_low) begin
      inc = 1'b1;
      wait_cyc(6);
    end
    if (acts) begin
      if (dir) exp_pos = (exp_pos == PMAX) ? exp_pos : exp_pos + 1;
      else     exp_pos = (exp_pos == 0)    ? exp_pos : exp_pos - 1;
    end
  endtask

  // raise select with the strobe high and measure the busy period
  task automatic store_and_count(input string req);
    int len;
    cs_n = 1'b1;
    exp_nv = exp_pos;
    len = 0;
    for (int k = 0; k < 10 && !busy; k++) wait_cyc(1);
    while (busy && len < 1000) begin
      len++;
      wait_cyc(1);
    end
    check(len == SCYC, req, len, SCYC);
  endtask

  task automatic do_reset(input bit cold);
    cs_n = 1'b1; inc = 1'b1; up_dn = 1'b0;
    rst_n = 1'b0;
    if (cold) por_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1; por_n = 1'b1;
    wait_cyc(8);
    if (cold) exp_nv = INIT;
    exp_pos = exp_nv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; cs_n = 1'b1; inc = 1'b1; up_dn = 1'b0;
    exp_nv = INIT;
    // R9: cold reset state
    do_reset(1'b1);
    check_pos("R9 cold");
    check(busy == 1'b0, "R9 busy idle", int'(busy), 0);

    // R2/R4: sweep up into the top limit
    cs_n = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b0, 1'b1);
      check_pos("R2/R4 up");
    end
    // R3/R4: sweep down into the bottom limit
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b0, 1'b1);
      check_pos("R3/R4 down");
    end
    // R2/R3: mixed direction changes while selected
    for (int i = 0; i < 12; i++) begin
      step(logic'((i % 3) != 0), 1'b0, 1'b1);
      check_pos("R2/R3 mixed");
    end

    // R6: leave select with strobe high -> store
    store_and_count("R6 busy length");
    check_pos("R6 pos kept");

    // R5: strobe pulses while deselected
    for (int i = 0; i < 6; i++) begin
      step(logic'(i[0]), 1'b0, 1'b0);
      check_pos("R5 deselected");
    end

    // R7: leave select with strobe low -> no store
    cs_n = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    cs_n = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 60; k++) begin
        wait_cyc(1);
        if (busy) seen++;
      end
      check(seen == 0, "R7 no busy", seen, 0);
    end
    check_pos("R7 pos kept");
    inc = 1'b1;
    wait_cyc(4);
    // R7/R9: warm reset recalls the older stored value
    do_reset(1'b0);
    check_pos("R7/R9 warm recall");

    // R8: strobe ignored during a store
    cs_n = 1'b0;
    wait_cyc(4);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    cs_n = 1'b1;
    exp_nv = exp_pos;
    for (int k = 0; k < 10 && !busy; k++) wait_cyc(1);
    cs_n = 1'b0; up_dn = 1'b1;
    wait_cyc(3);
    inc = 1'b0;
    wait_cyc(4);
    inc = 1'b1;
    wait_cyc(4);
    check(busy == 1'b1, "R8 still busy", int'(busy), 1);
    wait_cyc(SCYC);
    check_pos("R8 ignored");
    step(1'b0, 1'b0, 1'b1);
    check_pos("R3 after store");
    store_and_count("R6 second store");

    // R9: warm then cold recall
    do_reset(1'b0);
    check_pos("R9 warm");
    do_reset(1'b1);
    check_pos("R9 cold again");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule